// File: doc/BRIEF.md
# Two-Way Read Cache with On-Chip RAM Fallback

This block sits between a processor-side word port and an external-memory port that can burst. With caching enabled it keeps a 4 KB two-way set-associative store. Each line holds four 32-bit words. A cacheable read that hits is answered in the cycle it is presented. A cacheable read that misses fetches the whole line as a four-beat burst, marks the line valid, and then serves the read from the array. Stores are written through to external memory and update the array only when they hit. Any access whose address bit 31 is set skips the arrays and goes out as a single-word transfer.

When the enable input is low, the data storage is no longer a cache. It becomes plain RAM mapped at a fixed window starting at `RAM_BASE`, with a size of twice one way. The default base suits an instruction-side instance; a data-side instance would use `32'hFFE0_1000`. Accesses inside the window are served locally in the cycle they are presented. Accesses outside the window pass to external memory unchanged.

Both data ports use valid/ready. The processor holds address, write flag and write data stable from the raising of `cpu_req_valid` until it sees `cpu_req_ready`. Read data is valid in the cycle `cpu_req_ready` is high. The block holds `mem_req_*` stable until `mem_req_ready`. Response beats on `mem_rsp_valid` have no back-pressure: the block always takes them. `cache_en` must not change while a request is in flight.

Top module: `rc_cache`

## Requirements
- R1: A cacheable read (enable high, address bit 31 zero) that hits returns the stored word with `cpu_req_ready` in the cycle it is presented. It raises no external request. No two ways ever hit together.
- R2: A cacheable read that misses raises one request with `mem_req_burst`=1 and the address aligned to the line (bits [3:0] zero). It accepts four beats, holding words 0 to 3 in order. Only after that does it return the requested word.
- R3: Replacement is least-recently-used, with one bit per set. After reset way 0 is the victim. A read hit or a refill makes the other way the next victim.
- R4: With caching enabled, a read whose address bit 31 is 1 goes out as a single access (`mem_req_burst`=0) and returns the external word. It never allocates, so repeating it goes out again.
- R5: Every store with caching enabled goes out as a single external write. A store that hits also updates the cached word. A store that misses does not allocate.
- R6: A `flush` pulse, or `cache_en` low for a cycle, invalidates every line from the next cycle on. Reset clears all valid and LRU bits.
- R7: With `cache_en` low, reads and writes inside the window [`RAM_BASE`, `RAM_BASE`+2·`SETS`·`WORDS`·4) act as RAM. Window offset bit (4+log2 `SETS`) picks the way, the bits below it pick set and word, and a word written is read back unchanged.
- R8: A RAM-mode access inside the window completes in the cycle it is presented and raises no external request.
- R9: A RAM-mode access outside the window, including the word just past its end and the word just below its base, goes out as a single access with the address unchanged.
- R10: Once raised, `mem_req_valid`, `mem_req_addr` and `mem_req_we` stay stable until `mem_req_ready` is seen.
- R11: A flush that falls in the cycle a refill writes its tag wins. The line stays invalid, and the pending read fetches the line again before it is answered.
- R12: After reset, with no request presented, `mem_req_valid` and `cpu_req_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cache_en | input | 1 | 1 = cache mode, 0 = RAM mode |
| flush | input | 1 | Invalidate all lines |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request completes this cycle |
| cpu_req_addr | input | 32 | Byte address (word aligned) |
| cpu_req_we | input | 1 | 1 = store |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_req_ready` |
| mem_req_valid | output | 1 | External request present |
| mem_req_ready | input | 1 | External request accepted |
| mem_req_addr | output | 32 | External address |
| mem_req_we | output | 1 | External write |
| mem_req_wdata | output | 32 | External write data |
| mem_req_burst | output | 1 | 1 = four-beat line read |
| mem_rsp_valid | input | 1 | Read beat present |
| mem_rsp_data | input | 32 | Read beat data |

## Verification
Two events can land on the same clock edge: the refill's tag-and-valid write and the invalidation from `flush`. The bench's memory model raises `flush` in exactly the cycle after the last beat, which is the cycle in which the refill commits its tag. The bench then judges the outcome from the ports. A second burst for the same line must appear, and the word finally returned must equal the memory contents. The memory model also varies its acceptance delay, so that held requests meet the refill and write-through paths.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MREQ,
    ST_BEATS,
    ST_FILL,
    ST_BWAIT
  } rc_state_e;
endpackage

// File: rtl/rc_tag_store.sv
module rc_tag_store #(
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [1:0]       hit_vec,
  output logic             lru_way,
  input  logic             touch_en,
  input  logic             touch_way,
  input  logic             fill_en,
  input  logic             fill_way,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;

    assign hit_vec[w] = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == 1'(w)) tag_q[fill_idx] <= fill_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            vld_q <= '0;
      else if (clear)                        vld_q <= '0;
      else if (fill_en && fill_way == 1'(w)) vld_q[fill_idx] <= 1'b1;
    end
  end

  // lru bit = way to evict next
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lru_q <= '0;
    else if (fill_en)  lru_q[fill_idx] <= ~fill_way;
    else if (touch_en) lru_q[lk_idx] <= ~touch_way;
  end

  assign lru_way = lru_q[lk_idx];

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (g_way[0].vld_q == '0 && g_way[1].vld_q == '0)); // R6
  AST_ONE_WAY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R1
  AST_FILL_POINTS_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> lru_q[$past(fill_idx)] == !$past(fill_way)); // R3
endmodule

// File: rtl/rc_data_store.sv
module rc_data_store #(
  parameter int SETS  = 128,
  parameter int WORDS = 4,
  parameter int IDX_W = $clog2(SETS),
  parameter int WRD_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             w_way,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [WRD_W-1:0] w_word,
  input  logic [31:0]      w_data,
  input  logic [IDX_W-1:0] r_idx,
  input  logic [WRD_W-1:0] r_word,
  output logic [31:0]      rd0,
  output logic [31:0]      rd1
);
  localparam int DEPTH = 2 * SETS * WORDS;

  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[{w_way, w_idx, w_word}] <= w_data;
  end

  assign rd0 = mem_q[{1'b0, r_idx, r_word}];
  assign rd1 = mem_q[{1'b1, r_idx, r_word}];
endmodule

// File: rtl/rc_cache.sv
module rc_cache #(
  parameter int          SETS     = 128,
  parameter int          WORDS    = 4,
  parameter logic [31:0] RAM_BASE = 32'hFFE0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cache_en,
  input  logic        flush,
  input  logic        cpu_req_valid,
  output logic        cpu_req_ready,
  input  logic [31:0] cpu_req_addr,
  input  logic        cpu_req_we,
  input  logic [31:0] cpu_req_wdata,
  output logic [31:0] cpu_rdata,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  output logic        mem_req_we,
  output logic [31:0] mem_req_wdata,
  output logic        mem_req_burst,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  import rc_pkg::*;

  localparam int WRD_W     = $clog2(WORDS);
  localparam int IDX_W     = $clog2(SETS);
  localparam int OFF_W     = WRD_W + 2;
  localparam int TAG_W     = 31 - OFF_W - IDX_W;
  localparam int WIN_BYTES = 2 * SETS * WORDS * 4;

  rc_state_e st_q, st_d;
  logic [WRD_W-1:0] beat_q;
  logic             burst_q, vict_q;

  logic [IDX_W-1:0] idx, rd_idx, d_idx;
  logic [WRD_W-1:0] wsel, rd_word, d_word;
  logic [TAG_W-1:0] tag;
  logic [31:0]      win_off, rd0, rd1, arr_word, d_data;
  logic             in_win, ram_acc, cacheable, hit, hit_way, rd_sel;
  logic [1:0]       hit_vec;
  logic             lru_way, touch, fill, d_we, d_way;

  assign idx       = cpu_req_addr[OFF_W+IDX_W-1:OFF_W];
  assign wsel      = cpu_req_addr[OFF_W-1:2];
  assign tag       = cpu_req_addr[30:OFF_W+IDX_W];
  assign win_off   = cpu_req_addr - RAM_BASE;
  assign in_win    = win_off < 32'(WIN_BYTES);
  assign ram_acc   = !cache_en && in_win;
  assign cacheable = cache_en && !cpu_req_addr[31];
  assign hit       = cacheable && (|hit_vec);
  assign hit_way   = hit_vec[1];

  assign rd_idx   = ram_acc ? win_off[OFF_W+IDX_W-1:OFF_W] : idx;
  assign rd_word  = ram_acc ? win_off[OFF_W-1:2] : wsel;
  assign rd_sel   = ram_acc ? win_off[OFF_W+IDX_W] : hit_way;
  assign arr_word = rd_sel ? rd1 : rd0;

  rc_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .clear(flush || !cache_en),
    .lk_idx(idx), .lk_tag(tag), .hit_vec(hit_vec), .lru_way(lru_way),
    .touch_en(touch), .touch_way(hit_way),
    .fill_en(fill), .fill_way(vict_q), .fill_idx(idx), .fill_tag(tag)
  );

  rc_data_store #(.SETS(SETS), .WORDS(WORDS), .IDX_W(IDX_W), .WRD_W(WRD_W)) u_data (
    .clk(clk), .we(d_we), .w_way(d_way), .w_idx(d_idx), .w_word(d_word),
    .w_data(d_data), .r_idx(rd_idx), .r_word(rd_word), .rd0(rd0), .rd1(rd1)
  );

  always_comb begin
    st_d          = st_q;
    cpu_req_ready = 1'b0;
    cpu_rdata     = arr_word;
    mem_req_valid = 1'b0;
    d_we          = 1'b0;
    d_way         = rd_sel;
    d_idx         = rd_idx;
    d_word        = rd_word;
    d_data        = cpu_req_wdata;
    touch         = 1'b0;
    fill          = 1'b0;
    case (st_q)
      ST_IDLE: if (cpu_req_valid) begin
        if (ram_acc) begin
          cpu_req_ready = 1'b1;
          d_we          = cpu_req_we;
        end else if (hit && !cpu_req_we) begin
          cpu_req_ready = 1'b1;
          touch         = 1'b1;
        end else begin
          st_d = ST_MREQ;
        end
      end
      ST_MREQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) begin
          if (burst_q) st_d = ST_BEATS;
          else if (cpu_req_we) begin
            cpu_req_ready = 1'b1;
            d_we          = hit;
            st_d          = ST_IDLE;
          end else st_d = ST_BWAIT;
        end
      end
      ST_BEATS: begin
        d_way  = vict_q;
        d_idx  = idx;
        d_word = beat_q;
        d_data = mem_rsp_data;
        d_we   = mem_rsp_valid;
        if (mem_rsp_valid && beat_q == WRD_W'(WORDS - 1)) st_d = ST_FILL;
      end
      ST_FILL: begin
        fill = 1'b1;
        st_d = ST_IDLE;
      end
      ST_BWAIT: if (mem_rsp_valid) begin
        cpu_req_ready = 1'b1;
        cpu_rdata     = mem_rsp_data;
        st_d          = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      beat_q  <= '0;
      burst_q <= 1'b0;
      vict_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && st_d == ST_MREQ) begin
        burst_q <= cacheable && !cpu_req_we;
        vict_q  <= lru_way;
      end
      if (st_q == ST_MREQ) beat_q <= '0;
      else if (st_q == ST_BEATS && mem_rsp_valid) beat_q <= beat_q + 1'b1;
    end
  end

  assign mem_req_burst = mem_req_valid && burst_q;
  assign mem_req_addr  = burst_q ? {cpu_req_addr[31:OFF_W], OFF_W'(0)} : cpu_req_addr;
  assign mem_req_we    = mem_req_valid && cpu_req_we;
  assign mem_req_wdata = cpu_req_wdata;

  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R10
  AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_burst |-> mem_req_addr[OFF_W-1:0] == '0); // R2
  AST_NC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && cache_en && mem_req_addr[31] |-> !mem_req_burst); // R4
  AST_RAM_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready && ram_acc |-> !mem_req_valid); // R8
endmodule

// File: tb/rc_cache_bench.sv
`timescale 1ns/1ps
module rc_cache_bench;
  localparam logic [31:0] BASE = 32'hFFE0_1000;
  localparam int NWORDS = 2 * 4 * 4;

  logic clk = 1'b0, rst_n = 1'b0, cache_en = 1'b1;
  logic flush_main = 1'b0, flush_fill = 1'b0, flush;
  logic cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic cpu_req_ready, mem_req_valid, mem_req_we, mem_req_burst;
  logic [31:0] cpu_rdata, mem_req_addr, mem_req_wdata;
  logic mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  assign flush = flush_main | flush_fill;
  always #2 clk = ~clk;

  rc_cache #(.SETS(4), .WORDS(4), .RAM_BASE(BASE)) u_rc_cache (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flush(flush),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_addr(cpu_req_addr), .cpu_req_we(cpu_req_we),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rdata(cpu_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_we(mem_req_we),
    .mem_req_wdata(mem_req_wdata), .mem_req_burst(mem_req_burst),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0, errors = 0;
  int n_burst = 0, n_rd = 0, n_wr = 0, lat = 0;
  logic arm_flush = 1'b0;
  logic [31:0] last_burst, last_rd, last_wr;
  logic [31:0] wmem [logic [31:0]];

  function automatic logic [31:0] mval(input logic [31:0] a);
    if (wmem.exists(a)) return wmem[a];
    return (a * 32'h0001_0003) ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [31:0] ca(input int t, input int s, input int w);
    return 32'((t << 6) | (s << 4) | (w << 2));
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // external memory model
  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [31:0] a;
        logic burst;
        repeat (lat) @(negedge clk);
        a = mem_req_addr; burst = mem_req_burst;
        if (mem_req_we) begin wmem[a] = mem_req_wdata; n_wr++; last_wr = a; end
        else if (burst) begin n_burst++; last_burst = a; end
        else begin n_rd++; last_rd = a; end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (burst) begin
          for (int b = 0; b < 4; b++) begin
            mem_rsp_valid = 1'b1; mem_rsp_data = mval(a + 32'(4 * b));
            @(negedge clk);
          end
          mem_rsp_valid = 1'b0;
          if (arm_flush) begin
            flush_fill = 1'b1; arm_flush = 1'b0;
            @(negedge clk);
            flush_fill = 1'b0;
          end
        end else if (!mem_req_we) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = mval(a);
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  logic [31:0] rd;
  int waits;

  task automatic acc(input logic [31:0] a, input logic we, input logic [31:0] wd);
    @(negedge clk);
    cpu_req_addr = a; cpu_req_we = we; cpu_req_wdata = wd; cpu_req_valid = 1'b1;
    waits = 0;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; waits++; end
    rd = cpu_rdata;
    @(posedge clk);
    #1 cpu_req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    int b0, r0, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!mem_req_valid, "R12 mem_req_valid after reset", 32'(mem_req_valid), 0);
    chk(!cpu_req_ready, "R12 cpu_req_ready after reset", 32'(cpu_req_ready), 0);

    // R2 refill and R1 hits over every set, two tags each
    for (int s = 0; s < 4; s++) begin
      lat = s % 3;
      for (int t = 1; t <= 2; t++) begin
        b0 = n_burst;
        acc(ca(t, s, 1), 1'b0, '0);
        chk(n_burst == b0 + 1, "R2 one burst per miss", 32'(n_burst - b0), 1);
        chk(last_burst == ca(t, s, 0), "R2 burst address aligned", last_burst, ca(t, s, 0));
        chk(rd == mval(ca(t, s, 1)), "R2 refill word", rd, mval(ca(t, s, 1)));
        for (int w = 0; w < 4; w++) begin
          acc(ca(t, s, w), 1'b0, '0);
          chk(n_burst == b0 + 1 && waits == 0, "R1 hit same cycle, no traffic", 32'(waits), 0);
          chk(rd == mval(ca(t, s, w)), "R1 hit data", rd, mval(ca(t, s, w)));
        end
      end
    end

    // R3 LRU: touch tag 1, bring tag 3 (evicts tag 2)
    for (int s = 0; s < 4; s++) begin
      acc(ca(1, s, 0), 1'b0, '0);
      b0 = n_burst;
      acc(ca(3, s, 2), 1'b0, '0);
      chk(n_burst == b0 + 1, "R3 new tag misses", 32'(n_burst - b0), 1);
      acc(ca(1, s, 3), 1'b0, '0);
      chk(n_burst == b0 + 1, "R3 recently used way kept", 32'(n_burst - b0), 1);
      acc(ca(2, s, 3), 1'b0, '0);
      chk(n_burst == b0 + 2, "R3 LRU way evicted", 32'(n_burst - b0), 2);
      chk(rd == mval(ca(2, s, 3)), "R3 refetched data", rd, mval(ca(2, s, 3)));
    end

    // R4 non-cacheable bypass
    lat = 1;
    b0 = n_burst; r0 = n_rd;
    for (int k = 0; k < 2; k++) begin
      acc(32'h8000_0000 | ca(1, 0, 0), 1'b0, '0);
      chk(rd == mval(32'h8000_0000 | ca(1, 0, 0)), "R4 bypass data", rd, mval(32'h8000_0000 | ca(1, 0, 0)));
      chk(last_rd == (32'h8000_0000 | ca(1, 0, 0)), "R4 bypass address", last_rd, 32'h8000_0000 | ca(1, 0, 0));
    end
    chk(n_rd == r0 + 2 && n_burst == b0, "R4 single accesses, no allocation", 32'(n_rd - r0), 2);

    // R5 write-through
    w0 = n_wr; b0 = n_burst;
    acc(ca(1, 0, 2), 1'b1, 32'hDEAD_0001);
    chk(n_wr == w0 + 1 && last_wr == ca(1, 0, 2), "R5 hit store goes out", last_wr, ca(1, 0, 2));
    acc(ca(1, 0, 2), 1'b0, '0);
    chk(rd == 32'hDEAD_0001 && n_burst == b0, "R5 hit store updates line", rd, 32'hDEAD_0001);
    acc(ca(5, 1, 0), 1'b1, 32'hBEEF_0002);
    chk(n_wr == w0 + 2 && n_burst == b0, "R5 miss store single write", 32'(n_wr - w0), 2);
    acc(ca(5, 1, 0), 1'b0, '0);
    chk(n_burst == b0 + 1, "R5 miss store did not allocate", 32'(n_burst - b0), 1);
    chk(rd == 32'hBEEF_0002, "R5 written value from memory", rd, 32'hBEEF_0002);

    // R6 flush and disable invalidate
    @(negedge clk); flush_main = 1'b1; @(negedge clk); flush_main = 1'b0;
    b0 = n_burst;
    acc(ca(1, 0, 2), 1'b0, '0);
    chk(n_burst == b0 + 1 && rd == 32'hDEAD_0001, "R6 flush invalidates", 32'(n_burst - b0), 1);
    @(negedge clk); cache_en = 1'b0; @(negedge clk); cache_en = 1'b1;
    acc(ca(1, 0, 2), 1'b0, '0);
    chk(n_burst == b0 + 2, "R6 disable invalidates", 32'(n_burst - b0), 2);

    // R11 flush collides with the tag write
    lat = 0; b0 = n_burst; arm_flush = 1'b1;
    acc(ca(6, 2, 3), 1'b0, '0);
    chk(n_burst == b0 + 2, "R11 flush wins over fill", 32'(n_burst - b0), 2);
    chk(rd == mval(ca(6, 2, 3)), "R11 final data", rd, mval(ca(6, 2, 3)));

    // R7 R8 RAM mode sweep
    @(negedge clk); cache_en = 1'b0;
    w0 = n_wr; r0 = n_rd; b0 = n_burst;
    for (int i = NWORDS - 1; i >= 0; i--) begin
      acc(BASE + 32'(4 * i), 1'b1, 32'(i) * 32'h0101_0101 ^ 32'hA5);
      chk(waits == 0, "R8 RAM write same cycle", 32'(waits), 0);
    end
    for (int i = 0; i < NWORDS; i++) begin
      acc(BASE + 32'(4 * i), 1'b0, '0);
      chk(rd == (32'(i) * 32'h0101_0101 ^ 32'hA5), "R7 RAM readback", rd, 32'(i) * 32'h0101_0101 ^ 32'hA5);
    end
    chk(n_wr == w0 && n_rd == r0 && n_burst == b0, "R8 no external traffic", 32'(n_wr - w0 + n_rd - r0), 0);

    // R9 outside the window
    acc(BASE + 32'(4 * NWORDS), 1'b0, '0);
    chk(n_rd == r0 + 1 && last_rd == BASE + 32'(4 * NWORDS), "R9 past end goes out", last_rd, BASE + 32'(4 * NWORDS));
    chk(rd == mval(BASE + 32'(4 * NWORDS)), "R9 external data", rd, mval(BASE + 32'(4 * NWORDS)));
    acc(BASE - 32'd4, 1'b0, '0);
    chk(n_rd == r0 + 2 && last_rd == BASE - 32'd4, "R9 below base goes out", last_rd, BASE - 32'd4);
    acc(32'h0000_0100, 1'b1, 32'h1234_5678);
    chk(n_wr == w0 + 1 && last_wr == 32'h0000_0100, "R9 low write goes out", last_wr, 32'h0000_0100);
    chk(n_burst == b0, "R9 never bursts in RAM mode", 32'(n_burst - b0), 0);

    summary();
  end
endmodule